// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible register file of a simple LCD controller. A 32-bit register bus reaches six word offsets from 0x00 to 0x14: a control word, three timing words, a status word and a subpanel word. The stored configuration is decoded onto dedicated outputs (enable, mono, TFT, palette load mode, width minus one, height minus one, subpanel word) for the pixel fetch and panel timing logic elsewhere in the controller.

Three one-cycle event strobes from that logic (palette loaded, frame done, sync error) set sticky status flags. A single level-sensitive interrupt line is driven from the flags and a two-bit mask in the control word. The sync error flag interrupts without any mask. Turning the controller on or off through the control word also clears or sets flags. The bus read path is combinational from the address. Every write takes effect at the clock edge that samples it.

Top module: `lcd_ctl_regs`

## Requirements
- R1: The control word at offset 0x00 holds enable in bit 0, mono in bit 1, interrupt mask in bits 4:3, TFT in bit 7 and palette load mode in bits 21:20. These drive the field outputs. Reading it returns those fields, the TFT bit repeated in bit 23, and 0xfe000c34 ORed in.
- R2: Bits of a control write under mask 0x01cff300 are retained and read back. All other control bits not named in R1 read as zero unless forced by the constant.
- R3: Offsets 0x04 and 0x08 keep width-1 and height-1 in bits 9:0, driven on the size outputs. Bits 31:10 are kept as a separate field. A read of 0x04 has bits 3:0 forced to one. A read of 0x08 returns the word as stored.
- R4: A read of offset 0x0C returns the stored word with bits 31:26 forced to one. Offset 0x14 stores the written word ANDed with 0xa1ffffff and drives it on the subpanel output.
- R5: The status word at 0x10 reads frame done in bit 0, sync error in bit 2 and palette loaded in bit 6, with zeros elsewhere. Writes to 0x10 change nothing.
- R6: The interrupt is high exactly when frame done is set with mask bit 0, palette loaded is set with mask bit 1, or sync error is set. The sync error term ignores the mask.
- R7: A control write that changes enable from 1 to 0 clears sync error. The same write sets frame done unless the written palette load mode is 1, in which case frame done is left unchanged.
- R8: A control write that changes enable from 0 to 1 clears frame done and palette loaded.
- R9: After reset every stored field and flag is zero. Control reads 0xfe000c34, timing 0x04 reads 0x0000000f, timing 0x0C reads 0xfc000000, status reads 0, and the interrupt is low.
- R10: Offsets other than the six listed read as zero, and writes to them change no register.
- R11: A strobe sets its flag at the next edge, except in a cycle whose control write changes enable. In that cycle all three strobes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when not selected |
| evPalette | input | 1 | Palette loaded strobe |
| evFrame | input | 1 | Frame done strobe |
| evSync | input | 1 | Sync error strobe |
| irqOut | output | 1 | Level interrupt |
| ctlEnable | output | 1 | Controller enable |
| ctlMono | output | 1 | Monochrome panel |
| ctlTft | output | 1 | TFT panel |
| ctlPalMode | output | 2 | Palette load mode |
| widthM1 | output | SIZE_W | Width minus one |
| heightM1 | output | SIZE_W | Height minus one |
| subpanelCfg | output | 32 | Subpanel word |

## Verification
The assertions assume a single bus access per cycle. They also assume that strobes in the cycle of a status write come only from the event inputs, so a status write with no strobe must leave the flags as they were. The stimulus issues one transaction per cycle and raises strobes only in idle cycles or in control-write cycles chosen on purpose. This covers the strobe discard on enable changes and the strobe pass-through on control writes that leave enable unchanged.

// File: rtl/lcd_ctl_pkg.sv
package lcd_ctl_pkg;
  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] CTL_KEEP_MASK = 32'h01cf_f300;
  localparam logic [DATA_W-1:0] CTL_RD_ONES   = 32'hfe00_0c34;
  localparam logic [DATA_W-1:0] T0_RD_ONES    = 32'h0000_000f;
  localparam logic [DATA_W-1:0] T2_RD_ONES    = 32'hfc00_0000;
  localparam logic [DATA_W-1:0] SUB_MASK      = 32'ha1ff_ffff;

  typedef enum logic [2:0] {
    SEL_CTL, SEL_T0, SEL_T1, SEL_T2, SEL_STAT, SEL_SUB, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic wrCtl;
    logic wrT0;
    logic wrT1;
    logic wrT2;
    logic wrSub;
    logic setFrame;
    logic clrFrame;
    logic setPal;
    logic clrPal;
    logic setSync;
    logic clrSync;
  } regCmd_t;
endpackage

// File: rtl/lcd_ctl_decode.sv
module lcd_ctl_decode
  import lcd_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEnBit,
  input  logic [1:0]        wrMode,
  input  logic              curEnable,
  input  logic              evPalette,
  input  logic              evFrame,
  input  logic              evSync,
  output regSel_e           regSel,
  output regCmd_t           cmd
);
  localparam logic [ADDR_W-1:0] OFF_CTL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_T0   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_T1   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_T2   = ADDR_W'(8'h0c);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_SUB  = ADDR_W'(8'h14);

  logic doWrite, enRise, enFall, enChange;

  always_comb begin
    regSel = SEL_NONE;
    if (busSel) begin
      unique case (busAddr)
        OFF_CTL:  regSel = SEL_CTL;
        OFF_T0:   regSel = SEL_T0;
        OFF_T1:   regSel = SEL_T1;
        OFF_T2:   regSel = SEL_T2;
        OFF_STAT: regSel = SEL_STAT;
        OFF_SUB:  regSel = SEL_SUB;
        default:  regSel = SEL_NONE;
      endcase
    end
  end

  assign doWrite  = busSel && busWr;
  assign enRise   = doWrite && (regSel == SEL_CTL) && wrEnBit && !curEnable;
  assign enFall   = doWrite && (regSel == SEL_CTL) && !wrEnBit && curEnable;
  assign enChange = enRise || enFall;

  always_comb begin
    cmd          = '0;
    cmd.wrCtl    = doWrite && (regSel == SEL_CTL);
    cmd.wrT0     = doWrite && (regSel == SEL_T0);
    cmd.wrT1     = doWrite && (regSel == SEL_T1);
    cmd.wrT2     = doWrite && (regSel == SEL_T2);
    cmd.wrSub    = doWrite && (regSel == SEL_SUB);
    cmd.setFrame = (enFall && (wrMode != 2'd1)) || (evFrame && !enChange);
    cmd.clrFrame = enRise;
    cmd.setPal   = evPalette && !enChange;
    cmd.clrPal   = enRise;
    cmd.setSync  = evSync && !enChange;
    cmd.clrSync  = enFall;
  end
endmodule

// File: rtl/lcd_ctl_store.sv
module lcd_ctl_store
  import lcd_ctl_pkg::*;
#(
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  regCmd_t           cmd,
  input  regSel_e           regSel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic              enable,
  output logic              mono,
  output logic              tft,
  output logic [1:0]        palMode,
  output logic [SIZE_W-1:0] widthM1,
  output logic [SIZE_W-1:0] heightM1,
  output logic [DATA_W-1:0] subpanel,
  output logic [2:0]        stFlags
);
  localparam int HI_W = DATA_W - SIZE_W;

  logic [1:0]        irqMask;
  logic [DATA_W-1:0] ctlKeep;
  logic [HI_W-1:0]   t0Hi, t1Hi;
  logic [DATA_W-1:0] t2Word;
  logic              frameQ, palQ, syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      mono     <= 1'b0;
      tft      <= 1'b0;
      palMode  <= 2'd0;
      irqMask  <= 2'd0;
      ctlKeep  <= '0;
      t0Hi     <= '0;
      t1Hi     <= '0;
      widthM1  <= '0;
      heightM1 <= '0;
      t2Word   <= '0;
      subpanel <= '0;
    end else begin
      if (cmd.wrCtl) begin
        enable  <= wdata[0];
        mono    <= wdata[1];
        irqMask <= wdata[4:3];
        tft     <= wdata[7];
        palMode <= wdata[21:20];
        ctlKeep <= wdata & CTL_KEEP_MASK;
      end
      if (cmd.wrT0) begin
        t0Hi    <= wdata[DATA_W-1:SIZE_W];
        widthM1 <= wdata[SIZE_W-1:0];
      end
      if (cmd.wrT1) begin
        t1Hi     <= wdata[DATA_W-1:SIZE_W];
        heightM1 <= wdata[SIZE_W-1:0];
      end
      if (cmd.wrT2)  t2Word   <= wdata;
      if (cmd.wrSub) subpanel <= wdata & SUB_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= 1'b0;
      palQ   <= 1'b0;
      syncQ  <= 1'b0;
    end else begin
      if (cmd.clrFrame)      frameQ <= 1'b0;
      else if (cmd.setFrame) frameQ <= 1'b1;
      if (cmd.clrPal)        palQ   <= 1'b0;
      else if (cmd.setPal)   palQ   <= 1'b1;
      if (cmd.clrSync)       syncQ  <= 1'b0;
      else if (cmd.setSync)  syncQ  <= 1'b1;
    end
  end

  assign irqOut  = (frameQ && irqMask[0]) || (palQ && irqMask[1]) || syncQ;
  assign stFlags = {syncQ, palQ, frameQ};

  always_comb begin
    unique case (regSel)
      SEL_CTL:  rdata = CTL_RD_ONES | ctlKeep
                      | (DATA_W'(tft) << 23) | (DATA_W'(palMode) << 20)
                      | (DATA_W'(tft) << 7)  | (DATA_W'(irqMask) << 3)
                      | (DATA_W'(mono) << 1) | DATA_W'(enable);
      SEL_T0:   rdata = {t0Hi, widthM1} | T0_RD_ONES;
      SEL_T1:   rdata = {t1Hi, heightM1};
      SEL_T2:   rdata = t2Word | T2_RD_ONES;
      SEL_STAT: rdata = (DATA_W'(palQ) << 6) | (DATA_W'(syncQ) << 2) | DATA_W'(frameQ);
      SEL_SUB:  rdata = subpanel;
      default:  rdata = '0;
    endcase
  end

  AST_SYNC_FORCES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    syncQ |-> irqOut); // R6
  AST_UNMASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!syncQ && irqMask == 2'd0) |-> !irqOut); // R6
  AST_STATUS_BITS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_STAT) |-> ((rdata & ~32'h0000_0045) == '0)); // R5
endmodule

// File: rtl/lcd_ctl_regs.sv
module lcd_ctl_regs
  import lcd_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              evPalette,
  input  logic              evFrame,
  input  logic              evSync,
  output logic              irqOut,
  output logic              ctlEnable,
  output logic              ctlMono,
  output logic              ctlTft,
  output logic [1:0]        ctlPalMode,
  output logic [SIZE_W-1:0] widthM1,
  output logic [SIZE_W-1:0] heightM1,
  output logic [31:0]       subpanelCfg
);
  regSel_e    regSel;
  regCmd_t    cmd;
  logic [2:0] stFlags;

  lcd_ctl_decode #(.ADDR_W(ADDR_W)) uDecode (
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .wrEnBit   (busWdata[0]),
    .wrMode    (busWdata[21:20]),
    .curEnable (ctlEnable),
    .evPalette (evPalette),
    .evFrame   (evFrame),
    .evSync    (evSync),
    .regSel    (regSel),
    .cmd       (cmd)
  );

  lcd_ctl_store #(.SIZE_W(SIZE_W)) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .regSel   (regSel),
    .wdata    (busWdata),
    .rdata    (busRdata),
    .irqOut   (irqOut),
    .enable   (ctlEnable),
    .mono     (ctlMono),
    .tft      (ctlTft),
    .palMode  (ctlPalMode),
    .widthM1  (widthM1),
    .heightM1 (heightM1),
    .subpanel (subpanelCfg),
    .stFlags  (stFlags)
  );

  AST_FALL_SETS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == '0 && !busWdata[0] && ctlEnable
     && busWdata[21:20] != 2'd1) |=> stFlags[0]); // R7
  AST_FALL_CLEARS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == '0 && !busWdata[0] && ctlEnable)
    |=> !stFlags[2]); // R7
  AST_RISE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == '0 && busWdata[0] && !ctlEnable)
    |=> (!stFlags[0] && !stFlags[1])); // R8
  AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_W'(8'h10) && !evFrame && !evPalette && !evSync)
    |=> $stable(stFlags)); // R5
  AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel) |-> (busRdata == '0)); // R10
endmodule

// File: tb/lcd_ctl_regs_test.sv
module lcd_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evPalette = 1'b0, evFrame = 1'b0, evSync = 1'b0;
  logic        irqOut, ctlEnable, ctlMono, ctlTft;
  logic [1:0]  ctlPalMode;
  logic [9:0]  widthM1, heightM1;
  logic [31:0] subpanelCfg;
  logic        probe = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  lcd_ctl_regs uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evPalette(evPalette),
    .evFrame(evFrame), .evSync(evSync), .irqOut(irqOut), .ctlEnable(ctlEnable),
    .ctlMono(ctlMono), .ctlTft(ctlTft), .ctlPalMode(ctlPalMode),
    .widthM1(widthM1), .heightM1(heightM1), .subpanelCfg(subpanelCfg)
  );

  // kinds: 0 read data, 1 irq, 2 width-1, 3 height-1, 4 subpanel, 5 {tft,mode,mono,en}
  always @(negedge clk) begin
    if (probe && !finished) begin
      if (sb.size() == 0) begin
        miscompares++;
        $display("FAIL scoreboard empty");
      end else begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = busRdata;
          1: act = {31'd0, irqOut};
          2: act = {22'd0, widthM1};
          3: act = {22'd0, heightM1};
          4: act = subpanelCfg;
          default: act = {27'd0, ctlTft, ctlPalMode, ctlMono, ctlEnable};
        endcase
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic drive(input logic s, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic fr, input logic pa,
                       input logic sy, input logic pr);
    @(posedge clk);
    #1;
    busSel = s; busWr = w; busAddr = a; busWdata = d;
    evFrame = fr; evPalette = pa; evSync = sy; probe = pr;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1, 1, a, d, 0, 0, 0, 0);
  endtask

  task automatic wrEv(input logic [7:0] a, input logic [31:0] d,
                      input logic fr, input logic pa, input logic sy);
    drive(1, 1, a, d, fr, pa, sy, 0);
  endtask

  task automatic pulse(input logic fr, input logic pa, input logic sy);
    drive(0, 0, 8'h00, 32'h0, fr, pa, sy, 0);
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb.push_back('{0, e, tag});
    drive(1, 0, a, 32'h0, 0, 0, 0, 1);
  endtask

  task automatic portChk(input int k, input logic [31:0] e, input string tag);
    sb.push_back('{k, e, tag});
    drive(0, 0, 8'h00, 32'h0, 0, 0, 0, 1);
  endtask

  function automatic logic [31:0] ctlExp(input logic [31:0] v);
    return 32'hfe00_0c34 | (v & 32'h01cf_f300) | (v & 32'h0030_009b) | ({31'd0, v[7]} << 23);
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    // R9 reset state
    rdChk(8'h00, 32'hfe00_0c34, "R9 ctl");
    rdChk(8'h10, 32'h0, "R9 status");
    rdChk(8'h04, 32'h0000_000f, "R9 t0");
    rdChk(8'h0c, 32'hfc00_0000, "R9 t2");
    portChk(1, 32'h0, "R9 irq");
    // R3 size fields
    wr(8'h04, 32'h0001_2345);
    rdChk(8'h04, 32'h0001_234f, "R3 t0 read");
    portChk(2, 32'h345, "R3 width");
    wr(8'h08, 32'habcd_e123);
    rdChk(8'h08, 32'habcd_e123, "R3 t1 read");
    portChk(3, 32'h123, "R3 height");
    // R4
    wr(8'h0c, 32'h0000_1234);
    rdChk(8'h0c, 32'hfc00_1234, "R4 t2");
    wr(8'h14, 32'hffff_ffff);
    rdChk(8'h14, 32'ha1ff_ffff, "R4 sub read");
    portChk(4, 32'ha1ff_ffff, "R4 sub port");
    // R10 undefined offset
    wr(8'h18, 32'hffff_ffff);
    rdChk(8'h18, 32'h0, "R10 undef read");
    rdChk(8'h14, 32'ha1ff_ffff, "R10 sub kept");
    rdChk(8'h0c, 32'hfc00_1234, "R10 t2 kept");
    rdChk(8'h00, 32'hfe00_0c34, "R10 ctl kept");
    // R1 enable
    wr(8'h00, 32'h1);
    rdChk(8'h00, ctlExp(32'h1), "R1 ctl enable");
    pulse(1, 0, 0);
    rdChk(8'h10, 32'h01, "R5 frame bit");
    portChk(1, 32'h0, "R6 frame masked");
    wr(8'h00, 32'h09);
    portChk(1, 32'h1, "R6 frame mask0");
    pulse(0, 1, 0);
    rdChk(8'h10, 32'h41, "R5 palette bit");
    wr(8'h10, 32'h0);
    rdChk(8'h10, 32'h41, "R5 write ignored");
    wr(8'h00, 32'h11);
    portChk(1, 32'h1, "R6 palette mask1");
    wr(8'h00, 32'h01);
    portChk(1, 32'h0, "R6 mask zero");
    pulse(0, 0, 1);
    rdChk(8'h10, 32'h45, "R5 sync bit");
    portChk(1, 32'h1, "R6 sync unmasked");
    // R7 disable, mode 0
    wr(8'h00, 32'h0);
    rdChk(8'h10, 32'h41, "R7 disable mode0");
    portChk(1, 32'h0, "R7 irq after disable");
    // R8 enable clears
    wr(8'h00, 32'h1);
    rdChk(8'h10, 32'h0, "R8 enable clears");
    // R7 disable, mode 1
    pulse(0, 0, 1);
    wr(8'h00, 32'h0010_0000);
    rdChk(8'h10, 32'h0, "R7 disable mode1");
    rdChk(8'h00, ctlExp(32'h0010_0000), "R1 ctl mode1");
    // R11 strobes discarded on enable change
    wrEv(8'h00, 32'h1, 1, 1, 1);
    rdChk(8'h10, 32'h0, "R11 discard");
    portChk(1, 32'h0, "R11 irq");
    wrEv(8'h00, 32'h1, 1, 0, 0);
    rdChk(8'h10, 32'h01, "R11 pass");
    // R2 full control word
    wr(8'h00, 32'hffff_ffff);
    rdChk(8'h00, 32'hffff_ffbf, "R2 ctl all ones");
    portChk(5, 32'h1f, "R1 fields");
    portChk(1, 32'h1, "R6 mask3 frame");
    wr(8'h00, 32'hffff_fffe);
    rdChk(8'h10, 32'h01, "R7 disable mode3");
    drive(0, 0, 8'h00, 32'h0, 0, 0, 0, 0);
    @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule